// File: doc/BRIEF.md
# Coprocessor CPU-Space Bus Slave

This block lets a main processor reach a bank of sixteen 32-bit coprocessor interface registers over an asynchronous, strobe-driven bus. A cycle is recognised by its function code and a fixed address pattern in CPU space, not by an ordinary memory range. A 3-bit identifier strapped on each instance lets several identical coprocessors share one bus. Four address bits pick the register.

The strobes arrive from another clock domain. Address strobe and data strobe each pass through a two-stage synchroniser before the handshake state machine uses them. When the registered chip select, the address strobe and the data strobe are all active, the slave acknowledges with both acknowledge bits low, which marks a 32-bit port. On a read it drives the data bus one cycle before the acknowledge. It releases the acknowledge and the bus only after the address strobe goes high. Every access is a single transfer; bursts are never taken.

Top module: `cpif_slave`

## Requirements
- R1: The block is selected only when the function code `fc` equals 3'b111 (CPU space).
- R2: The block is selected only when `addr[19:16]` equals 4'b0010 (coprocessor access).
- R3: The block is selected only when `addr[15:13]` equals the strapped `cp_id`.
- R4: The block is selected only when every address bit outside `addr[19:13]` and `addr[4:1]` is 0, that is `addr[31:20]`, `addr[12:5]` and `addr[0]`.
- R5: `cs_q` shows the decode of R1 to R4 one clock edge after the address is presented, whatever the strobes are doing, and is 0 during reset.
- R6: On a read (`rw`=1) with `as_n` and `ds_n` both low, `data_oe` rises with the register chosen by `addr[4:1]` on `data_o` at the 3rd clock edge, and `dsack_n` goes to 2'b00 at the 4th edge.
- R7: On a write (`rw`=0) with both strobes low, `dsack_n` goes to 2'b00 at the 3rd clock edge, and `data_i` is stored into the selected register on that edge.
- R8: Selectors whose bit is set in `RO_MASK` (by default selectors 0 and 1) are read-only: writes to them are acknowledged but have no effect, and a read returns `RO_TAG` OR-ed with the selector value (by default 32'hC0C0_0000 | selector).
- R9: Writable registers reset to 0 and each holds its own value; a write to one selector leaves every other selector unchanged.
- R10: `dsack_n` is only ever 2'b11 (idle) or 2'b00 (32-bit acknowledge); the two bits move together.
- R11: The acknowledge holds while `as_n` stays low; after `as_n` goes high, `dsack_n` returns to 2'b11 and `data_oe` to 0 (with `data_o` at 0) at the 3rd clock edge.
- R12: With `as_n` low but `ds_n` high, no acknowledge is given and the bus is not driven.
- R13: If `as_n` is already low when reset ends, no cycle starts until `as_n` has been seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fc | input | 3 | Function code of the current bus cycle |
| addr | input | 32 | Address bus |
| cp_id | input | 3 | Strapped coprocessor identifier |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 for read, 0 for write |
| data_i | input | 32 | Write data from the processor |
| data_o | output | 32 | Read data toward the processor, 0 when not driven |
| data_oe | output | 1 | Data bus drive enable |
| dsack_n | output | 2 | Data-transfer acknowledge, active low |
| cs_q | output | 1 | Registered chip select |

## Verification
Chip select is due one edge after the address changes. The read drive is due on the third edge after the strobes fall and the read acknowledge on the fourth. The write acknowledge is due on the third edge, and the release on the third edge after the address strobe rises. Every task changes inputs on a falling edge, counts rising edges with explicit waits, and samples on the next falling edge. It also samples one edge early, so an output that arrives a cycle early or late is caught.

// File: rtl/cpif_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the coprocessor interface slave.
package cpif_pkg;
    localparam int ADDR_W = 32;
    localparam int FC_W   = 3;
    localparam int ID_W   = 3;
    localparam int SEL_W  = 4;
    localparam int NREG   = 1 << SEL_W;

    // Field positions the processor side decodes.
    localparam int ID_LO  = 13;
    localparam int TAG_LO = 16;
    localparam int SEL_LO = 1;

    localparam logic [FC_W-1:0] FC_CPU_SPACE  = 3'b111;
    localparam logic [3:0]      CP_ACCESS_TAG = 4'b0010;

    // Address bits that carry meaning in a coprocessor access; all others must be 0.
    localparam logic [ADDR_W-1:0] USED_BITS =
        (ADDR_W'(4'hF) << TAG_LO) | (ADDR_W'(3'h7) << ID_LO) | (ADDR_W'(4'hF) << SEL_LO);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_ACK   = 2'd2
    } bus_state_e;
endpackage

// File: rtl/cpif_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for asynchronous strobes.
// Assumes each bit is independent; reset loads RESET_VAL into every stage.
module cpif_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cpif_decode.sv
`timescale 1ns/1ps
// CPU-space coprocessor decode: function code, access tag, identifier and
// zero check on unused address bits. Registers the chip select and selector.
// Assumes the address and function code are stable while the strobes are low.
module cpif_decode
    import cpif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   cp_id,
    output logic              cs_q,
    output logic [SEL_W-1:0]  sel_q
);
    logic fc_hit, tag_hit, id_hit, stray_bits, match;

    // Combinational pattern match of the current cycle.
    always_comb begin
        fc_hit     = (fc == FC_CPU_SPACE);
        tag_hit    = (addr[TAG_LO +: 4] == CP_ACCESS_TAG);
        id_hit     = (addr[ID_LO +: ID_W] == cp_id);
        stray_bits = |(addr & ~USED_BITS);
        match      = fc_hit && tag_hit && id_hit && !stray_bits;
    end

    // Register the select and the register selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            cs_q  <= match;
            sel_q <= addr[SEL_LO +: SEL_W];
        end
    end
endmodule

// File: rtl/cpif_regfile.sv
`timescale 1ns/1ps
// Sixteen interface registers. A set RO_MASK bit makes that word read-only,
// returning RO_TAG OR-ed with its index; writes to it are dropped.
module cpif_regfile
    import cpif_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter logic [NREG-1:0]  RO_MASK = 16'h0003,
    parameter logic [DATA_W-1:0] RO_TAG = 32'hC0C0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (RO_MASK[g]) begin : g_ro
            assign word[g] = RO_TAG | DATA_W'(g);
        end else begin : g_rw
            // Writable word: capture on a matching write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)                                  word[g] <= '0;
                else if (wr_en && (wr_sel == SEL_W'(g)))     word[g] <= wr_data;
            end
        end
    end

    assign rd_data = word[rd_sel];
endmodule

// File: rtl/cpif_slave.sv
`timescale 1ns/1ps
// Coprocessor interface bus slave: synchronised strobes, CPU-space decode,
// register file and acknowledge handshake for single 32-bit transfers.
// Assumes rw, addr and data_i are stable while as_n is low.
module cpif_slave
    import cpif_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [NREG-1:0]  RO_MASK     = 16'h0003,
    parameter logic [DATA_W-1:0] RO_TAG     = 32'hC0C0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   cp_id,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic [1:0]        dsack_n,
    output logic              cs_q
);
    logic [1:0]        strobe_sync;
    logic              as_act, ds_act;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] rd_data;
    logic              armed_q, start, wr_en;
    bus_state_e        state_q;
    logic [1:0]        dsack_q;
    logic              oe_q;
    logic [DATA_W-1:0] dout_q;

    // Reset value 0 treats both strobes as asserted until a real high is seen.
    cpif_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b00)) sync_i (
        .clk(clk), .rst_n(rst_n), .din({as_n, ds_n}), .dout(strobe_sync)
    );

    assign as_act = ~strobe_sync[1];
    assign ds_act = ~strobe_sync[0];

    cpif_decode decode_i (
        .clk(clk), .rst_n(rst_n), .fc(fc), .addr(addr), .cp_id(cp_id),
        .cs_q(cs_q), .sel_q(sel_q)
    );

    cpif_regfile #(.DATA_W(DATA_W), .RO_MASK(RO_MASK), .RO_TAG(RO_TAG)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel_q),
        .wr_data(data_i), .rd_sel(sel_q), .rd_data(rd_data)
    );

    // Cycle start condition and write strobe.
    always_comb begin
        start = (state_q == ST_IDLE) && armed_q && cs_q && as_act && ds_act;
        wr_en = start && !rw;
    end

    // Re-arm only after the address strobe has been seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (start)   armed_q <= 1'b0;
        else if (!as_act) armed_q <= 1'b1;
    end

    // Handshake state machine with registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dsack_q <= 2'b11;
            oe_q    <= 1'b0;
            dout_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && rw) begin
                        state_q <= ST_DRIVE;
                        oe_q    <= 1'b1;
                        dout_q  <= rd_data;
                    end else if (start) begin
                        state_q <= ST_ACK;
                        dsack_q <= 2'b00;
                    end
                end
                ST_DRIVE: begin
                    state_q <= ST_ACK;
                    dsack_q <= 2'b00;
                end
                ST_ACK: begin
                    if (!as_act) begin
                        state_q <= ST_IDLE;
                        dsack_q <= 2'b11;
                        oe_q    <= 1'b0;
                        dout_q  <= '0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    dsack_q <= 2'b11;
                    oe_q    <= 1'b0;
                    dout_q  <= '0;
                end
            endcase
        end
    end

    assign dsack_n = dsack_q;
    assign data_oe = oe_q;
    assign data_o  = dout_q;
endmodule

// File: rtl/cpif_slave_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the slave; observes ports only.
module cpif_slave_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe,
    input logic [1:0]        dsack_n,
    input logic              cs_q
);
    // Acknowledge only follows a registered select.
    assert_ack_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsack_n[0]) |-> $past(cs_q));

    // Bus drive only starts for a selected cycle.
    assert_drive_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(cs_q));

    // Read data is on the bus before the acknowledge.
    assert_data_before_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dsack_n[0]) && data_oe) |-> ($past(data_oe) && $stable(data_o)));

    // Drive and acknowledge are released together.
    assert_release_together_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsack_n[0]) |-> !data_oe);

    // Acknowledge persists while the address strobe is still low.
    assert_ack_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dsack_n == 2'b00 && !as_n && !$past(as_n)) |=> dsack_n == 2'b00);
endmodule

bind cpif_slave cpif_slave_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .data_o(data_o),
    .data_oe(data_oe), .dsack_n(dsack_n), .cs_q(cs_q)
);

// File: tb/cpif_slave_tb.sv
`timescale 1ns/1ps
// Directed bench for the coprocessor interface slave.
module cpif_slave_tb_top;
    localparam logic [31:0] RO_TAG = 32'hC0C0_0000;
    localparam logic [2:0]  MY_ID  = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fc = 3'b000;
    logic [31:0] addr = '0;
    logic [2:0]  cp_id = MY_ID;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b1;
    logic [31:0] data_i = '0;
    logic [31:0] data_o;
    logic        data_oe;
    logic [1:0]  dsack_n;
    logic        cs_q;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpif_slave dut_i (
        .clk(clk), .rst_n(rst_n), .fc(fc), .addr(addr), .cp_id(cp_id),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .data_i(data_i), .data_o(data_o),
        .data_oe(data_oe), .dsack_n(dsack_n), .cs_q(cs_q)
    );

    function automatic logic [31:0] cp_addr(input logic [2:0] id, input logic [3:0] sel);
        return 32'h0002_0000 | (32'(id) << 13) | (32'(sel) << 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Raise strobes and check release timing (R11).
    task automatic release_bus();
        as_n = 1'b1; ds_n = 1'b1;
        edges(2);
        chk("R11 ack held 2 edges after AS high", 32'(dsack_n), 32'h0);
        edges(1);
        chk("R11 dsack released", 32'(dsack_n), 32'h3);
        chk("R11 drive released", 32'(data_oe), 32'h0);
        chk("R11 data cleared", data_o, 32'h0);
    endtask

    // Write cycle with timing checks (R7, R10).
    task automatic do_write(input logic [3:0] sel, input logic [31:0] d);
        fc = 3'b111; addr = cp_addr(MY_ID, sel); rw = 1'b0; data_i = d;
        as_n = 1'b0; ds_n = 1'b0;
        edges(2);
        chk("R7 no write ack before 3rd edge", 32'(dsack_n), 32'h3);
        edges(1);
        chk("R7 R10 write ack both bits low", 32'(dsack_n), 32'h0);
        chk("R7 bus not driven on write", 32'(data_oe), 32'h0);
        release_bus();
    endtask

    // Read cycle with timing and data checks (R6).
    task automatic do_read(input logic [3:0] sel, input logic [31:0] exp, input string req);
        fc = 3'b111; addr = cp_addr(MY_ID, sel); rw = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        edges(2);
        chk("R6 no drive before 3rd edge", 32'(data_oe), 32'h0);
        edges(1);
        chk("R6 drive on 3rd edge", 32'(data_oe), 32'h1);
        chk("R6 ack after data", 32'(dsack_n), 32'h3);
        chk(req, data_o, exp);
        edges(1);
        chk("R6 R10 read ack both bits low", 32'(dsack_n), 32'h0);
        release_bus();
    endtask

    // Decode only, strobes idle (R5 with R1..R4 cases).
    task automatic decode_case(input logic [2:0] f, input logic [31:0] a,
                               input logic exp, input string req);
        as_n = 1'b1; ds_n = 1'b1;
        fc = f; addr = a;
        edges(1);
        chk(req, 32'(cs_q), 32'(exp));
    endtask

    // Full strobes on a non-matching cycle: no response allowed.
    task automatic ignored_cycle(input logic [2:0] f, input logic [31:0] a, input string req);
        fc = f; addr = a; rw = 1'b1; as_n = 1'b0; ds_n = 1'b0;
        edges(6);
        chk(req, {30'h0, dsack_n}, 32'h3);
        chk(req, 32'(data_oe), 32'h0);
        as_n = 1'b1; ds_n = 1'b1;
        edges(3);
    endtask

    // AS without DS must not acknowledge (R12).
    task automatic as_only();
        fc = 3'b111; addr = cp_addr(MY_ID, 4'd5); rw = 1'b1;
        as_n = 1'b0; ds_n = 1'b1;
        edges(6);
        chk("R12 no ack with DS high", 32'(dsack_n), 32'h3);
        chk("R12 no drive with DS high", 32'(data_oe), 32'h0);
        as_n = 1'b1;
        edges(3);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        // Reset with a valid read already strobed (R13 setup).
        fc = 3'b111; addr = cp_addr(MY_ID, 4'd0); rw = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        edges(4);
        chk("R5 cs_q low in reset", 32'(cs_q), 32'h0);
        chk("R10 dsack idle in reset", 32'(dsack_n), 32'h3);
        chk("R11 no drive in reset", 32'(data_oe), 32'h0);
        rst_n = 1'b1;
        edges(8);
        chk("R13 no ack while AS held from reset", 32'(dsack_n), 32'h3);
        chk("R13 no drive while AS held from reset", 32'(data_oe), 32'h0);
        as_n = 1'b1; ds_n = 1'b1;
        edges(3);

        // R9: reset values of writable registers.
        do_read(4'd7, 32'h0, "R9 writable reset value");
        do_read(4'd1, RO_TAG | 32'd1, "R8 read-only value sel 1");

        // R7, R9: writes and independent storage.
        do_write(4'd5, 32'hDEAD_BEEF);
        do_write(4'd15, 32'h1234_5678);
        do_read(4'd5, 32'hDEAD_BEEF, "R9 sel 5 readback");
        do_read(4'd15, 32'h1234_5678, "R9 sel 15 readback");
        do_read(4'd6, 32'h0, "R9 neighbour untouched");

        // R8: write to read-only selector ignored.
        do_write(4'd0, 32'hFFFF_FFFF);
        do_read(4'd0, RO_TAG, "R8 write to ro sel 0 ignored");

        // R1..R5: decode cases.
        decode_case(3'b111, cp_addr(MY_ID, 4'd3), 1'b1, "R5 cs_q on valid decode");
        decode_case(3'b101, cp_addr(MY_ID, 4'd3), 1'b0, "R1 wrong fc");
        decode_case(3'b111, cp_addr(MY_ID, 4'd3) ^ 32'h0001_0000, 1'b0, "R2 wrong tag");
        decode_case(3'b111, cp_addr(3'd4, 4'd3), 1'b0, "R3 wrong id");
        decode_case(3'b111, cp_addr(MY_ID, 4'd3) | 32'h0000_0100, 1'b0, "R4 stray bit 8");
        decode_case(3'b111, cp_addr(MY_ID, 4'd3) | 32'h0000_0001, 1'b0, "R4 stray bit 0");
        decode_case(3'b111, cp_addr(MY_ID, 4'd3) | 32'h8000_0000, 1'b0, "R4 stray bit 31");

        // R1..R4: ignored cycles at the ports.
        ignored_cycle(3'b110, cp_addr(MY_ID, 4'd5), "R1 no response wrong fc");
        ignored_cycle(3'b111, cp_addr(3'd2, 4'd5), "R3 no response wrong id");
        ignored_cycle(3'b111, cp_addr(MY_ID, 4'd5) | 32'h0010_0000, "R4 no response stray bit 20");

        // R12
        as_only();
        do_read(4'd5, 32'hDEAD_BEEF, "R9 value kept after ignored cycles");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule